// File: doc/BRIEF.md
# Windowed Ring Buffer Tracker

This block sits next to a writer that streams data into a region of memory. The region is cut into a ring of equal-sized windows. The block watches each write address and tracks three indexes: the window being written, the window after it (which the writer may already touch), and the oldest filled window that software owns.

When the writer moves out of the current window, that window is handed to software and a ready pulse is raised. Software takes the physical address of its window from a dedicated output. When it has finished with the window, it returns it with a done strobe. Writes outside the region raise an invalid pulse. A hand-off that would leave the writer without two free windows raises an overflow pulse instead.

Nothing is reset at frame end. A partly filled window stays where it is until more data arrives. Only dropping the enable input returns the ring to window zero, and the configuration is meant to change only while enable is low.

Top module: `winring_mgr`

## Requirements
- R1: While enabled, an in-range write whose address lies outside the current window (and that does not overflow) gives a one-cycle irq_ready pulse after the next clock edge. The same edge moves cur_idx to the old nxt_idx, moves nxt_idx one further, and adds one filled window. All index steps wrap to 0 after cfg_win_last (the window count minus one).
- R2: A write inside the current window causes no event and no index change. With 8-line windows and a 20-line stream, exactly 2 ready pulses occur and cur_idx ends at 2.
- R3: A hand-off is refused when the filled-window count, after any same-cycle done, is at least the window count minus 2. The block then pulses irq_overflow, and the indexes stay unchanged.
- R4: A write below cfg_base, or at or above cfg_base + (cfg_win_last+1)*cfg_win_bytes, pulses irq_invalid and changes no index.
- R5: A cpu_done strobe while at least one window is filled advances cpu_idx (with wrap) and releases that window. With no filled window, the strobe is ignored.
- R6: cpu_addr equals cfg_base + cpu_idx*cfg_win_bytes one cycle after any change.
- R7: Each of sts_ready, sts_invalid and sts_overflow is set by its own event and cleared only by its own clear input. If an event and its clear fall in the same cycle, the set wins.
- R8: While cfg_enable is low, cur_idx and cpu_idx are 0 and nxt_idx is 1 (0 for a single window). No window is filled, cpu_addr follows cfg_base, and writes and done strobes are ignored.
- R9: When a done and a hand-off fall in the same cycle, the done is counted first for the overflow decision.
- R10: During reset, every output is 0 except nxt_idx, which is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_enable | input | 1 | Run enable; low holds the ring at window 0 |
| cfg_base | input | 32 | Region start address |
| cfg_win_bytes | input | 32 | Window size in address units |
| cfg_win_last | input | 4 | Number of windows minus one |
| wr_valid | input | 1 | Writer issues a write this cycle |
| wr_addr | input | 32 | Address of the write |
| cpu_done | input | 1 | Software returns its window |
| clr_ready | input | 1 | Clear sts_ready |
| clr_invalid | input | 1 | Clear sts_invalid |
| clr_overflow | input | 1 | Clear sts_overflow |
| irq_ready | output | 1 | Window hand-off pulse |
| irq_invalid | output | 1 | Out-of-region write pulse |
| irq_overflow | output | 1 | Refused hand-off pulse |
| sts_ready | output | 1 | Sticky ready flag |
| sts_invalid | output | 1 | Sticky invalid flag |
| sts_overflow | output | 1 | Sticky overflow flag |
| cur_idx | output | 4 | Window being written |
| nxt_idx | output | 4 | Window after the current one |
| cpu_idx | output | 4 | Oldest window owned by software |
| cpu_addr | output | 32 | Start address of the software window |

## Verification
A done strobe and a window hand-off can land on the same edge. At a full ring, the outcome then depends on which one is counted first. The bench provokes this by holding the ring one window short of accepting a hand-off. It first proves that a lone write overflows, then repeats that write together with cpu_done, and expects a ready pulse with both cpu_idx and cur_idx stepping. A long mixed stream where every fifth write carries a done keeps hitting this case across the wrap, and each cycle is judged against the bench model.

// File: rtl/winring_pkg.sv
package winring_pkg;

    typedef struct packed {
        logic ready;
        logic invalid;
        logic overflow;
    } wr_evt_t;

endpackage

// File: rtl/winring_addr.sv
module winring_addr #(
    parameter int AW = 32,
    parameter int IW = 4
) (
    input  logic [AW-1:0] base,
    input  logic [AW-1:0] win_bytes,
    input  logic [IW-1:0] win_last,
    input  logic [AW-1:0] cur_start,
    input  logic [AW-1:0] addr,
    output logic          in_range,
    output logic          in_cur
);
    localparam int SW = AW + IW + 1;

    logic [IW:0]   nwin;
    logic [SW-1:0] span_x;
    logic [SW-1:0] base_x;
    logic [SW-1:0] addr_x;
    logic [SW-1:0] lim_x;
    logic [AW-1:0] off_cur;

    // R4: region limit is computed wide so it cannot wrap.
    always_comb begin
        nwin     = {1'b0, win_last} + (IW+1)'(1);
        span_x   = SW'(nwin) * SW'(win_bytes);
        base_x   = SW'(base);
        addr_x   = SW'(addr);
        lim_x    = base_x + span_x;
        in_range = (addr_x >= base_x) && (addr_x < lim_x);
    end

    // R2: membership of the current window from its tracked start.
    always_comb begin
        off_cur = addr - cur_start;
        in_cur  = (addr >= cur_start) && (off_cur < win_bytes);
    end

endmodule

// File: rtl/winring_ctrl.sv
module winring_ctrl
    import winring_pkg::*;
#(
    parameter int AW = 32,
    parameter int IW = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          en,
    input  logic [AW-1:0] base,
    input  logic [AW-1:0] win_bytes,
    input  logic [IW-1:0] win_last,
    input  logic          wr_valid,
    input  logic          in_range,
    input  logic          in_cur,
    input  logic          cpu_done,
    output logic [IW-1:0] cur_idx,
    output logic [IW-1:0] nxt_idx,
    output logic [IW-1:0] cpu_idx,
    output logic [AW-1:0] cur_start,
    output logic [AW-1:0] cpu_start,
    output wr_evt_t       evt
);
    localparam int PW = IW + 1;

    typedef struct packed {
        logic [IW-1:0] cur;
        logic [IW-1:0] nxt;
        logic [IW-1:0] cpu;
        logic [PW-1:0] pend;
        logic [AW-1:0] cur_start;
        logic [AW-1:0] cpu_start;
    } ring_t;

    ring_t         s_d, s_q;
    wr_evt_t       evt_d;
    logic [PW-1:0] nwin;
    logic          done_ok;
    logic [PW-1:0] pend_eff;
    logic [PW:0]   need;
    logic          ring_full;

    function automatic logic [IW-1:0] wrap_inc(input logic [IW-1:0] i,
                                               input logic [IW-1:0] last);
        return (i == last) ? '0 : i + IW'(1);
    endfunction

    function automatic logic [AW-1:0] wrap_start(input logic [AW-1:0] start,
                                                 input logic [IW-1:0] i,
                                                 input logic [IW-1:0] last,
                                                 input logic [AW-1:0] b,
                                                 input logic [AW-1:0] sz);
        return (i == last) ? b : start + sz;
    endfunction

    always_comb begin
        s_d       = s_q;
        evt_d     = '0;
        nwin      = {1'b0, win_last} + PW'(1);
        done_ok   = cpu_done && (s_q.pend != '0);                  // R5
        pend_eff  = s_q.pend - PW'(done_ok);                       // R9
        need      = {1'b0, pend_eff} + (PW+1)'(2);
        ring_full = need >= {1'b0, nwin};                          // R3
        if (!en) begin                                             // R8
            s_d.cur       = '0;
            s_d.nxt       = wrap_inc('0, win_last);
            s_d.cpu       = '0;
            s_d.pend      = '0;
            s_d.cur_start = base;
            s_d.cpu_start = base;
        end else begin
            if (done_ok) begin
                s_d.cpu       = wrap_inc(s_q.cpu, win_last);
                s_d.cpu_start = wrap_start(s_q.cpu_start, s_q.cpu, win_last,
                                           base, win_bytes);       // R6
                s_d.pend      = pend_eff;
            end
            if (wr_valid) begin
                if (!in_range) begin
                    evt_d.invalid = 1'b1;                          // R4
                end else if (!in_cur) begin
                    if (ring_full) begin
                        evt_d.overflow = 1'b1;                     // R3
                    end else begin
                        evt_d.ready   = 1'b1;                      // R1
                        s_d.cur       = s_q.nxt;
                        s_d.nxt       = wrap_inc(s_q.nxt, win_last);
                        s_d.cur_start = wrap_start(s_q.cur_start, s_q.cur,
                                                   win_last, base, win_bytes);
                        s_d.pend      = pend_eff + PW'(1);
                    end
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q.cur       <= '0;
            s_q.nxt       <= IW'(1);
            s_q.cpu       <= '0;
            s_q.pend      <= '0;
            s_q.cur_start <= '0;
            s_q.cpu_start <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign cur_idx   = s_q.cur;
    assign nxt_idx   = s_q.nxt;
    assign cpu_idx   = s_q.cpu;
    assign cur_start = s_q.cur_start;
    assign cpu_start = s_q.cpu_start;
    assign evt       = evt_d;

    // Checker-side values for the assertions below.
    logic [PW:0]   ring_sum;
    logic [PW:0]   ring_mod;
    logic [AW-1:0] cpu_addr_chk;
    always_comb begin
        ring_sum     = {2'b00, s_q.cpu} + {1'b0, s_q.pend};
        ring_mod     = (ring_sum >= {1'b0, nwin}) ? ring_sum - {1'b0, nwin} : ring_sum;
        cpu_addr_chk = base + AW'({{(AW-IW){1'b0}}, s_q.cpu} * win_bytes);
    end

    AST_NEXT_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
        (en && $past(en)) |-> s_q.nxt == ((s_q.cur == win_last) ? '0 : s_q.cur + IW'(1))); // R1
    AST_RING_CONSISTENT: assert property (@(posedge clk) disable iff (!rst_n)
        (en && $past(en)) |-> {2'b00, s_q.cur} == ring_mod); // R5
    AST_NO_OVERFLOW_MOVE: assert property (@(posedge clk) disable iff (!rst_n)
        evt_d.overflow |=> s_q.cur == $past(s_q.cur)); // R3
    AST_INVALID_NO_MOVE: assert property (@(posedge clk) disable iff (!rst_n)
        evt_d.invalid |=> (s_q.cur == $past(s_q.cur)) && (s_q.nxt == $past(s_q.nxt))); // R4
    AST_DISABLED_HOME: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> (s_q.cur == '0) && (s_q.cpu == '0) && (s_q.pend == '0)); // R8
    AST_CPU_ADDR_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
        (en && $past(en)) |-> s_q.cpu_start == cpu_addr_chk); // R6

endmodule

// File: rtl/winring_status.sv
module winring_status
    import winring_pkg::*;
(
    input  logic    clk,
    input  logic    rst_n,
    input  wr_evt_t evt,
    input  logic    clr_ready,
    input  logic    clr_invalid,
    input  logic    clr_overflow,
    output wr_evt_t pulse,
    output wr_evt_t sticky
);
    typedef struct packed {
        wr_evt_t pulse;
        wr_evt_t sticky;
    } stat_t;

    stat_t r_d, r_q;

    // R7: set has priority over the matching clear.
    always_comb begin
        r_d                 = r_q;
        r_d.pulse           = evt;
        r_d.sticky.ready    = (r_q.sticky.ready    & ~clr_ready)    | evt.ready;
        r_d.sticky.invalid  = (r_q.sticky.invalid  & ~clr_invalid)  | evt.invalid;
        r_d.sticky.overflow = (r_q.sticky.overflow & ~clr_overflow) | evt.overflow;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    assign pulse  = r_q.pulse;
    assign sticky = r_q.sticky;

    AST_EVENTS_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({evt.ready, evt.invalid, evt.overflow})); // R1
    AST_READY_STICKS: assert property (@(posedge clk) disable iff (!rst_n)
        r_q.pulse.ready |-> r_q.sticky.ready); // R7
    AST_OVERFLOW_STICKS: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.sticky.overflow && !clr_overflow) |=> r_q.sticky.overflow); // R7

endmodule

// File: rtl/winring_mgr.sv
module winring_mgr
    import winring_pkg::*;
#(
    parameter int AW = 32,
    parameter int IW = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cfg_enable,
    input  logic [AW-1:0] cfg_base,
    input  logic [AW-1:0] cfg_win_bytes,
    input  logic [IW-1:0] cfg_win_last,
    input  logic          wr_valid,
    input  logic [AW-1:0] wr_addr,
    input  logic          cpu_done,
    input  logic          clr_ready,
    input  logic          clr_invalid,
    input  logic          clr_overflow,
    output logic          irq_ready,
    output logic          irq_invalid,
    output logic          irq_overflow,
    output logic          sts_ready,
    output logic          sts_invalid,
    output logic          sts_overflow,
    output logic [IW-1:0] cur_idx,
    output logic [IW-1:0] nxt_idx,
    output logic [IW-1:0] cpu_idx,
    output logic [AW-1:0] cpu_addr
);
    logic          in_range;
    logic          in_cur;
    logic [AW-1:0] cur_start;
    wr_evt_t       evt;
    wr_evt_t       pulse;
    wr_evt_t       sticky;

    winring_addr #(.AW(AW), .IW(IW)) u_addr (
        .base      (cfg_base),
        .win_bytes (cfg_win_bytes),
        .win_last  (cfg_win_last),
        .cur_start (cur_start),
        .addr      (wr_addr),
        .in_range  (in_range),
        .in_cur    (in_cur)
    );

    winring_ctrl #(.AW(AW), .IW(IW)) u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .en        (cfg_enable),
        .base      (cfg_base),
        .win_bytes (cfg_win_bytes),
        .win_last  (cfg_win_last),
        .wr_valid  (wr_valid),
        .in_range  (in_range),
        .in_cur    (in_cur),
        .cpu_done  (cpu_done),
        .cur_idx   (cur_idx),
        .nxt_idx   (nxt_idx),
        .cpu_idx   (cpu_idx),
        .cur_start (cur_start),
        .cpu_start (cpu_addr),
        .evt       (evt)
    );

    winring_status u_stat (
        .clk          (clk),
        .rst_n        (rst_n),
        .evt          (evt),
        .clr_ready    (clr_ready),
        .clr_invalid  (clr_invalid),
        .clr_overflow (clr_overflow),
        .pulse        (pulse),
        .sticky       (sticky)
    );

    assign irq_ready    = pulse.ready;
    assign irq_invalid  = pulse.invalid;
    assign irq_overflow = pulse.overflow;
    assign sts_ready    = sticky.ready;
    assign sts_invalid  = sticky.invalid;
    assign sts_overflow = sticky.overflow;

endmodule

// File: tb/winring_mgr_test.sv
module winring_mgr_test;
    localparam int CLK_NS = 10;
    localparam int AW = 32;
    localparam int IW = 4;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          cfg_enable = 1'b0;
    logic [AW-1:0] cfg_base = 32'h1000;
    logic [AW-1:0] cfg_win_bytes = 32'h80;
    logic [IW-1:0] cfg_win_last = 4'd3;
    logic          wr_valid = 1'b0;
    logic [AW-1:0] wr_addr = '0;
    logic          cpu_done = 1'b0;
    logic          clr_ready = 1'b0;
    logic          clr_invalid = 1'b0;
    logic          clr_overflow = 1'b0;
    logic          irq_ready, irq_invalid, irq_overflow;
    logic          sts_ready, sts_invalid, sts_overflow;
    logic [IW-1:0] cur_idx, nxt_idx, cpu_idx;
    logic [AW-1:0] cpu_addr;

    always #(CLK_NS/2) clk = ~clk;

    winring_mgr #(.AW(AW), .IW(IW)) uut (
        .clk(clk), .rst_n(rst_n), .cfg_enable(cfg_enable), .cfg_base(cfg_base),
        .cfg_win_bytes(cfg_win_bytes), .cfg_win_last(cfg_win_last),
        .wr_valid(wr_valid), .wr_addr(wr_addr), .cpu_done(cpu_done),
        .clr_ready(clr_ready), .clr_invalid(clr_invalid), .clr_overflow(clr_overflow),
        .irq_ready(irq_ready), .irq_invalid(irq_invalid), .irq_overflow(irq_overflow),
        .sts_ready(sts_ready), .sts_invalid(sts_invalid), .sts_overflow(sts_overflow),
        .cur_idx(cur_idx), .nxt_idx(nxt_idx), .cpu_idx(cpu_idx), .cpu_addr(cpu_addr)
    );

    // Behavioural reference state
    int    m_cur = 0, m_nxt = 1, m_cpu = 0, m_pend = 0;
    longint m_addr = 0;
    bit    m_ir, m_ii, m_io, m_sr, m_si, m_so;
    int    n_cmp = 0, n_bad = 0, n_ready = 0;

    task automatic check(string req, string what, longint act, longint exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s %s actual=%0h expected=%0h at %0t", req, what, act, exp, $time);
        end
    endtask

    task automatic model_step();
        int n;
        bit done_ok, er, ei, eo;
        int pe;
        longint lo, hi, w;
        n  = int'(cfg_win_last) + 1;
        er = 0; ei = 0; eo = 0;
        if (!cfg_enable) begin
            m_cur = 0; m_nxt = (n > 1) ? 1 : 0; m_cpu = 0; m_pend = 0;
            m_addr = longint'(cfg_base);
        end else begin
            done_ok = cpu_done && (m_pend > 0);
            pe = m_pend - (done_ok ? 1 : 0);
            if (done_ok) begin
                m_cpu = (m_cpu + 1) % n;
                m_pend = pe;
            end
            if (wr_valid) begin
                lo = longint'(cfg_base);
                hi = lo + longint'(n) * longint'(cfg_win_bytes);
                if (longint'(wr_addr) < lo || longint'(wr_addr) >= hi) ei = 1;
                else begin
                    w = (longint'(wr_addr) - lo) / longint'(cfg_win_bytes);
                    if (w != longint'(m_cur)) begin
                        if (pe + 2 >= n) eo = 1;
                        else begin
                            er = 1;
                            m_cur = (m_cur + 1) % n;
                            m_nxt = (m_cur + 1) % n;
                            m_pend = pe + 1;
                        end
                    end
                end
            end
            m_addr = longint'(cfg_base) + longint'(m_cpu) * longint'(cfg_win_bytes);
        end
        m_sr = (m_sr && !clr_ready) || er;
        m_si = (m_si && !clr_invalid) || ei;
        m_so = (m_so && !clr_overflow) || eo;
        m_ir = er; m_ii = ei; m_io = eo;
    endtask

    task automatic compare_all();
        check("R1", "cur_idx", longint'(cur_idx), longint'(m_cur));
        check("R1", "nxt_idx", longint'(nxt_idx), longint'(m_nxt));
        check("R5", "cpu_idx", longint'(cpu_idx), longint'(m_cpu));
        check("R6", "cpu_addr", longint'(cpu_addr), m_addr);
        check("R1", "irq_ready", longint'(irq_ready), longint'(m_ir));
        check("R4", "irq_invalid", longint'(irq_invalid), longint'(m_ii));
        check("R3", "irq_overflow", longint'(irq_overflow), longint'(m_io));
        check("R7", "sts_ready", longint'(sts_ready), longint'(m_sr));
        check("R7", "sts_invalid", longint'(sts_invalid), longint'(m_si));
        check("R7", "sts_overflow", longint'(sts_overflow), longint'(m_so));
    endtask

    task automatic tick();
        @(posedge clk);
        model_step();
        @(negedge clk);
        compare_all();
        if (irq_ready) n_ready++;
        wr_valid = 0; cpu_done = 0; clr_ready = 0; clr_invalid = 0; clr_overflow = 0;
    endtask

    task automatic wr(longint a, bit d);
        wr_valid = 1; wr_addr = AW'(a); cpu_done = d;
        tick();
    endtask

    task automatic done_only();
        cpu_done = 1;
        tick();
    endtask

    task automatic summary();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    endtask

    initial begin
        #(CLK_NS * 200000);
        n_cmp++; n_bad++;
        $display("FAIL R8 watchdog actual=running expected=finished");
        summary();
        $finish;
    end

    initial begin
        int r0;
        longint b;
        // R10: reset values
        @(negedge clk); @(negedge clk);
        check("R10", "reset cur_idx", longint'(cur_idx), 0);
        check("R10", "reset nxt_idx", longint'(nxt_idx), 1);
        check("R10", "reset cpu_idx", longint'(cpu_idx), 0);
        check("R10", "reset cpu_addr", longint'(cpu_addr), 0);
        check("R10", "reset irqs", longint'({irq_ready, irq_invalid, irq_overflow}), 0);
        check("R10", "reset sticky", longint'({sts_ready, sts_invalid, sts_overflow}), 0);
        rst_n = 1;
        tick(); tick();
        cfg_enable = 1;
        tick();
        b = 64'h1000;

        // R2: 20 lines of 16 bytes, 8-line windows
        r0 = n_ready;
        for (int k = 0; k < 20; k++) wr(b + k * 16, 0);
        check("R2", "ready count over 20 lines", longint'(n_ready - r0), 2);
        check("R2", "cur_idx after 20 lines", longint'(cur_idx), 2);
        for (int k = 20; k < 24; k++) wr(b + k * 16, 0);

        // R3: ring short one window -> overflow
        wr(b + 24 * 16, 0);
        check("R3", "overflow pulse", longint'(irq_overflow), 1);
        check("R3", "cur held on overflow", longint'(cur_idx), 2);

        // R9: same write with done is accepted
        wr(b + 24 * 16, 1);
        check("R9", "ready with done", longint'(irq_ready), 1);
        check("R9", "cpu_idx stepped", longint'(cpu_idx), 1);
        check("R9", "cur_idx stepped", longint'(cur_idx), 3);

        // R4: below and at the limit
        wr(b - 4, 0);
        check("R4", "invalid below base", longint'(irq_invalid), 1);
        wr(b + 4 * 128, 0);
        check("R4", "invalid at limit", longint'(irq_invalid), 1);
        check("R4", "cur held on invalid", longint'(cur_idx), 3);

        // R7: independent clear
        clr_invalid = 1;
        tick();
        check("R7", "sts_invalid cleared", longint'(sts_invalid), 0);
        check("R7", "sts_ready kept", longint'(sts_ready), 1);
        check("R7", "sts_overflow kept", longint'(sts_overflow), 1);

        // R1 wrap, and R7 set beats clear
        done_only(); done_only();
        clr_ready = 1;
        wr(b, 0);
        check("R1", "cur wraps to 0", longint'(cur_idx), 0);
        check("R7", "set wins over clear", longint'(sts_ready), 1);

        // R5: done with nothing filled is ignored
        done_only();
        check("R5", "cpu_idx after last done", longint'(cpu_idx), 0);
        done_only();
        check("R5", "empty done ignored", longint'(cpu_idx), 0);

        // R8: disable resets and ignores traffic
        wr(b + 128, 0);
        cfg_enable = 0;
        tick();
        check("R8", "cur home", longint'(cur_idx), 0);
        check("R8", "cpu home", longint'(cpu_idx), 0);
        wr(b + 256, 1);
        check("R8", "write ignored", longint'({irq_ready, irq_invalid, irq_overflow}), 0);
        cfg_base = 32'h8000; cfg_win_bytes = 32'h40; cfg_win_last = 4'd15;
        tick();
        check("R8", "cpu_addr follows base", longint'(cpu_addr), 64'h8000);
        cfg_enable = 1;
        tick();

        // Mixed stream over 16 windows, done with every fifth write
        b = 64'h8000;
        for (int k = 0; k < 400; k++) wr(b + (k % 64) * 16, (k % 5) == 0);
        for (int k = 0; k < 20; k++) done_only();
        check("R6", "cpu_addr after stream", longint'(cpu_addr),
              longint'(cfg_base) + longint'(cpu_idx) * 64);

        summary();
        $finish;
    end

endmodule